// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block decides when a small processor core leaves its program to service an interrupt. Each of several sources reports events on an asynchronous input. The block synchronizes the input, detects its rising edge and latches the edge into a per-source pending flag. A flag stays set until software clears it. A flag is taken into account only when its per-source enable bit and the single global enable bit are both set. All three are zero after reset.

At an instruction boundary, an enabled and pending source makes the block tell the sequencer to jump to one shared vector address. The default vector is 0x004. In the same cycle the block stores the return address on a small circular hardware stack and clears the global enable, so handlers do not nest unless software re-enables them. A return request pops the stack, presents the stored address and sets the global enable again. The handler reads the flags to find out which source fired.

All pins are plain level or strobe controls. No pin uses a valid/ready handshake, and the sequencer never applies back-pressure. The take strobe is combinational and holds only during the boundary cycle in which it is seen.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the flags, per-source enables and global enable are all 0, `take_o` is 0 and `ret_addr_o` reads 0 (stack empty).
- R2: A rising edge on `evt_async[i]` sets `flags_o[i]` on the third rising clock edge after the input changes, not earlier. A level held high sets the flag only once: once the flag is cleared it stays clear until the input falls and rises again.
- R3: A flag latches its event regardless of its enable bit and of the global enable.
- R4: A 1 in bit i of `flag_clr` clears `flags_o[i]` at the next clock edge. If a new edge arrives at the same edge, the set wins.
- R5: `take_o` is 1 exactly when `instr_bound`, `gie_o` and some bit of `flags_o & ien_o` are all 1 and `reti` is 0. `vec_o` always reads the vector address 0x004.
- R6: On a take, `cur_pc` is pushed onto the stack and `gie_o` is 0 after the clock edge.
- R7: `ret_addr_o` shows the most recently pushed address. A `reti` strobe pops it and leaves `gie_o` at 1 after the edge.
- R8: Nested takes, allowed when software sets the global enable inside a handler, return their addresses in last-in, first-out order.
- R9: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry. After 9 pushes, 8 pops return the newest 8 addresses, and the stack is then empty and `ret_addr_o` reads 0.
- R10: When `reti` and a take condition occur in the same cycle, the return wins: `take_o` stays 0 and `gie_o` is 1 after the edge.
- R11: `gie_set` sets the global enable and `gie_clr` clears it. If both are asserted together, the clear wins. `ien_we` loads `ien_wdata` into the per-source enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_async | input | NSRC | Asynchronous event inputs, one per source |
| flag_clr | input | NSRC | Software clear mask for pending flags |
| ien_we | input | 1 | Write strobe for per-source enables |
| ien_wdata | input | NSRC | New per-source enable value |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| instr_bound | input | 1 | Sequencer is at an instruction boundary |
| cur_pc | input | PC_W | Return address to save on a take |
| reti | input | 1 | Return-from-interrupt strobe |
| flags_o | output | NSRC | Pending flags |
| ien_o | output | NSRC | Per-source enables |
| gie_o | output | 1 | Global enable |
| take_o | output | 1 | Jump to vector this boundary |
| vec_o | output | PC_W | Vector address |
| ret_addr_o | output | PC_W | Top of return stack (0 when empty) |

## Verification
A corrupted stack pointer or count shows up at the first `reti` as a wrong `ret_addr_o`, or as a non-zero value where the stack should be empty. The overwrite test exposes this after nine pushes. A global enable left set after a take shows up at the very next boundary as a second `take_o`, and `gie_o` shows it one cycle after the take. A synchronizer or edge detector with the wrong depth moves the flag by one cycle, and the check at the second and third edges catches that. A missing edge detector shows up as a flag that sets again while the input is held high.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/vic_sync_edge.sv
module vic_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R2
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vic_srcregs.sv
module vic_srcregs #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            ien_we,
  input  logic [NSRC-1:0] ien_wdata,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] ien_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      ien_o   <= '0;
    end else begin
      flags_o <= (flags_o & ~clr_i) | rise_i;
      if (ien_we) ien_o <= ien_wdata;
    end
  end

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_o & ~clr_i) & ~flags_o) == '0));

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> (($past(rise_i) & ~flags_o) == '0));
endmodule

// File: rtl/vic_stack.sv
module vic_stack
  import vic_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stk_op_e      op_i,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_dec;
  logic [PW-1:0] ptr_inc;
  logic [CW-1:0] cnt_q;

  assign ptr_inc = (ptr_q == PLAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? PLAST : ptr_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      case (op_i)
        STK_PUSH: begin
          ptr_q <= ptr_inc;
          if (cnt_q != CFULL) cnt_q <= cnt_q + 1'b1;
        end
        STK_POP: begin
          if (cnt_q != '0) begin
            ptr_q <= ptr_dec;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[g] <= '0;
        else if (op_i == STK_PUSH && ptr_q == PW'(g)) mem_q[g] <= push_data;
      end
    end
  endgenerate

  assign top_o = (cnt_q != '0) ? mem_q[ptr_dec] : '0;

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CFULL);

  // R7
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_POP && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_PUSH && cnt_q != CFULL) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned PC_W     = 12,
  parameter int unsigned STK_DEP  = 8,
  parameter int unsigned VEC_ADDR = 4,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_async,
  input  logic [NSRC-1:0] flag_clr,
  input  logic            ien_we,
  input  logic [NSRC-1:0] ien_wdata,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            instr_bound,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            reti,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] ien_o,
  output logic            gie_o,
  output logic            take_o,
  output logic [PC_W-1:0] vec_o,
  output logic [PC_W-1:0] ret_addr_o
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  logic [NSRC-1:0] rise;
  logic            pend_any;
  stk_op_e         stk_op;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      vic_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(evt_async[s]),
        .rise_o (rise[s])
      );
    end
  endgenerate

  vic_srcregs #(.NSRC(NSRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .clr_i    (flag_clr),
    .ien_we   (ien_we),
    .ien_wdata(ien_wdata),
    .flags_o  (flags_o),
    .ien_o    (ien_o)
  );

  assign pend_any = |(flags_o & ien_o);
  assign take_o   = instr_bound & gie_o & pend_any & ~reti;
  assign vec_o    = VEC;

  always_comb begin
    if (reti)        stk_op = STK_POP;
    else if (take_o) stk_op = STK_PUSH;
    else             stk_op = STK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_o <= 1'b0;
    else if (take_o)  gie_o <= 1'b0;
    else if (reti)    gie_o <= 1'b1;
    else if (gie_clr) gie_o <= 1'b0;
    else if (gie_set) gie_o <= 1'b1;
  end

  vic_stack #(.DEPTH(STK_DEP), .W(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (stk_op),
    .push_data(cur_pc),
    .top_o    (ret_addr_o)
  );

  // R6
  take_gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o);

  // R7
  reti_gie_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> gie_o);

  // R6
  take_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> ret_addr_o == $past(cur_pc));

  // R11
  gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_clr && !reti) |=> !gie_o);
endmodule

// File: tb/test_vic_ctrl.sv
module test_vic_ctrl;
  localparam int NSRC = 4;
  localparam int PC_W = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] evt_async = '0;
  logic [NSRC-1:0] flag_clr = '0;
  logic            ien_we = 1'b0;
  logic [NSRC-1:0] ien_wdata = '0;
  logic            gie_set = 1'b0;
  logic            gie_clr = 1'b0;
  logic            instr_bound = 1'b0;
  logic [PC_W-1:0] cur_pc = '0;
  logic            reti = 1'b0;
  logic [NSRC-1:0] flags_o, ien_o;
  logic            gie_o, take_o;
  logic [PC_W-1:0] vec_o, ret_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vic_ctrl #(.NSRC(NSRC), .PC_W(PC_W)) i_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_async(evt_async), .flag_clr(flag_clr),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .instr_bound(instr_bound), .cur_pc(cur_pc), .reti(reti),
    .flags_o(flags_o), .ien_o(ien_o), .gie_o(gie_o), .take_o(take_o),
    .vec_o(vec_o), .ret_addr_o(ret_addr_o)
  );

  // entry: [7:6] source, [5:2] enables, [1] global enable, [0] expected take
  localparam logic [7:0] VTBL [6] = '{
    {2'd0, 4'b0001, 1'b1, 1'b1},
    {2'd1, 4'b0001, 1'b1, 1'b0},
    {2'd2, 4'b0100, 1'b0, 1'b0},
    {2'd3, 4'b1000, 1'b1, 1'b1},
    {2'd1, 4'b1111, 1'b1, 1'b1},
    {2'd2, 4'b1011, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_gie_set();
    gie_set = 1'b1;
    tick(1);
    gie_set = 1'b0;
  endtask

  task automatic clr_flags(input logic [NSRC-1:0] m);
    flag_clr = m;
    tick(1);
    flag_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 flags", flags_o, 0);
    chk("R1 ien", ien_o, 0);
    chk("R1 gie", gie_o, 0);
    chk("R1 take", take_o, 0);
    chk("R1 ret", ret_addr_o, 0);
    chk("R5 vec", vec_o, 12'h004);

    // table walk
    for (int k = 0; k < 6; k++) begin
      logic [1:0] src;
      logic [3:0] en;
      logic       ge, ex;
      {src, en, ge, ex} = VTBL[k];
      do_reset();
      ien_we = 1'b1; ien_wdata = en; tick(1); ien_we = 1'b0;
      chk("R11 ien write", ien_o, en);
      if (ge) pulse_gie_set();
      chk("R11 gie set", gie_o, ge);
      evt_async[src] = 1'b1;
      tick(2);
      chk("R2 flag not yet", flags_o, 0);
      tick(1);
      chk("R2/R3 flag set", flags_o, 4'(1) << src);
      evt_async[src] = 1'b0;
      cur_pc = 12'h100 + 12'(k);
      instr_bound = 1'b1;
      #1;
      chk("R5 take", take_o, ex);
      if (ex) chk("R5 vector", vec_o, 12'h004);
      tick(1);
      instr_bound = 1'b0;
      if (ex) begin
        chk("R6 gie cleared", gie_o, 0);
        chk("R7 ret addr", ret_addr_o, 12'h100 + 12'(k));
        #1 chk("R6 no second take", take_o, 0);
        reti = 1'b1; tick(1); reti = 1'b0;
        chk("R7 gie restored", gie_o, 1);
        chk("R7 stack empty", ret_addr_o, 0);
      end else begin
        chk("R5 gie unchanged", gie_o, ge);
        chk("R5 nothing pushed", ret_addr_o, 0);
      end
    end

    // R2: held level sets only once
    do_reset();
    evt_async[1] = 1'b1;
    tick(3);
    chk("R2 held set", flags_o, 4'b0010);
    clr_flags(4'b0010);
    chk("R4 cleared", flags_o, 0);
    tick(4);
    chk("R2 held no reset", flags_o, 0);
    evt_async[1] = 1'b0;
    tick(3);
    evt_async[1] = 1'b1;
    tick(3);
    chk("R2 new edge", flags_o, 4'b0010);
    evt_async[1] = 1'b0;

    // R4: set wins over coincident clear
    do_reset();
    evt_async[2] = 1'b1;
    tick(2);
    flag_clr = 4'b0100;
    tick(1);
    flag_clr = '0;
    chk("R4 set wins", flags_o, 4'b0100);
    evt_async[2] = 1'b0;

    // R11: clear wins over set
    do_reset();
    pulse_gie_set();
    gie_set = 1'b1; gie_clr = 1'b1; tick(1); gie_set = 1'b0; gie_clr = 1'b0;
    chk("R11 clear wins", gie_o, 0);

    // R10: return beats take
    do_reset();
    ien_we = 1'b1; ien_wdata = 4'b0001; tick(1); ien_we = 1'b0;
    evt_async[0] = 1'b1; tick(3); evt_async[0] = 1'b0;
    pulse_gie_set();
    instr_bound = 1'b1; reti = 1'b1; cur_pc = 12'h3AB;
    #1 chk("R10 take suppressed", take_o, 0);
    tick(1);
    instr_bound = 1'b0; reti = 1'b0;
    chk("R10 gie set", gie_o, 1);
    chk("R10 nothing pushed", ret_addr_o, 0);

    // R8/R9: nine nested takes, then eight returns
    for (int n = 0; n < 9; n++) begin
      if (n > 0) pulse_gie_set();
      cur_pc = 12'h200 + 12'(n);
      instr_bound = 1'b1;
      #1 chk("R8 nested take", take_o, 1);
      tick(1);
      instr_bound = 1'b0;
    end
    for (int n = 8; n >= 1; n--) begin
      chk("R8/R9 pop order", ret_addr_o, 12'h200 + 12'(n));
      reti = 1'b1; tick(1); reti = 1'b0;
    end
    chk("R9 empty after overwrite", ret_addr_o, 0);
    chk("R7 gie after pops", gie_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule